// File: doc/BRIEF.md
# Secure-side security controller register file

This block is the register interface that secure software uses to configure a security controller. It answers a 32-bit memory-mapped slave bus over a 4 KB window, decodes word offsets, and keeps the configuration that the rest of the controller consumes. That configuration covers the response policy for blocked secure accesses, the non-secure-callable setting, the interrupt enables for the peripheral protection units, and the bridge interrupt enables. It drives each setting onto a dedicated output.

It also collects interrupt requests. Pulses from the peripheral protection units are latched into a sticky status register, which software clears by writing ones. Level signals from the memory protection units are sampled into a read-only status word. A bank of twelve identification bytes reports the block's identity, and one parameter selects between two identity variants.

Reads return data one cycle after the request, with no wait states. A read narrower than a word returns the addressed bytes in the low lanes. A write narrower than a word is dropped without any effect.

Top module: `sec_cfg_regs`

## Requirements
- R1: After reset, `respCfgOut`, `nscCfgOut`, `ppcIntEnOut`, `ppcIntStatOut` and `busRdata` are all zero, and the bridge enable reads as zero.
- R2: A read (`busSel`=1, `busWrite`=0) sets `busRdata` on the next rising clock edge. The decode ignores `busAddr[1:0]`. A full-word read returns the whole register.
- R3: The access size code is 0 for a byte, 1 for a halfword and 2 for a word; code 3 reads as a word. A byte read returns the register shifted right by 8×`busAddr[1:0]`, keeping bits [7:0]. A halfword read applies the same shift and keeps bits [15:0]. All upper bits of the result are zero.
- R4: A write with a size code other than 2 changes no register and no output.
- R5: A word write to offset 0x10 keeps only bit 0, which drives `respCfgOut`. A word write to offset 0x14 keeps only bits [1:0], which drive `nscCfgOut`. Both offsets read back the stored value.
- R6: A word write to offset 0x28 stores the data ANDed with 0x00F000F3. The stored value drives `ppcIntEnOut` and reads back at 0x28.
- R7: Interrupt pulses from the protection units set sticky status bits. `apbPpcIrq[0]` sets bit 0 and `apbPpcIrq[1]` sets bit 1. `apbExpPpcIrq[i]` sets bit 4+i and `ahbExpPpcIrq[i]` sets bit 20+i. The status reads at offset 0x20 and drives `ppcIntStatOut`.
- R8: A word write to offset 0x24 clears every status bit that is set in the data ANDed with 0x00F000F3. A request that is high in the same cycle keeps its bit set.
- R9: Offset 0x1C reads the memory-protection status sampled on the previous clock. Bits [NUM_MPC-1:0] come from `mpcIrq` and bits starting at 16 come from `mpcExpIrq`. Writes to this offset are ignored.
- R10: Offset 0x40 always reads 0. Offset 0x48 keeps only bits [31:16] of a word write. A write to 0x44 has no effect.
- R11: Reads of offset 0x24, offset 0x44 or any undecoded offset return 0. Writes to the read-only offsets 0x1C, 0x20, 0x40 and 0xFD0–0xFFC change nothing.
- R12: Word offsets 0xFD0 to 0xFFC each read one identification byte, in the order 04,00,00,00,52,B8,0B,00,0D,F0,05,B1. When `ID_VARIANT`=1, the byte at offset 0xFE8 reads 2B instead of 0B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 12 | Byte offset in the window |
| busSize | input | 2 | Size code: 0 byte, 1 half, 2 word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the request |
| mpcIrq | input | NUM_MPC | Memory protection status levels |
| mpcExpIrq | input | NUM_EXP_MPC | Expansion memory protection status levels |
| apbPpcIrq | input | 2 | Internal peripheral protection interrupt requests |
| apbExpPpcIrq | input | 4 | Expansion peripheral protection requests, first group |
| ahbExpPpcIrq | input | 4 | Expansion peripheral protection requests, second group |
| respCfgOut | output | 1 | Secure response configuration |
| nscCfgOut | output | 2 | Non-secure-callable configuration |
| ppcIntEnOut | output | 32 | Protection interrupt enables |
| ppcIntStatOut | output | 32 | Sticky protection interrupt status |

## Verification
The hardest case to reach is a clear that lands while the same request is still asserted. In that case set must beat clear. The bench holds one request line high over the clear write and reads the bit back before it releases the line. It also creates sparse status patterns with single-cycle pulses. It then clears masked and unmasked bit positions, so it can show that bits outside 0x00F000F3 can neither be cleared nor enabled. Sub-word reads at each lane offset, and narrow writes to registers that already hold ones, show the lane selection and the write drop at the ports.

// File: rtl/sec_cfg_pkg.sv
package sec_cfg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned APB_PPCS = 2;
  localparam int unsigned EXP_PPCS = 4;
  localparam int unsigned APB_EXP_BASE = 4;
  localparam int unsigned AHB_EXP_BASE = 20;
  localparam int unsigned MPC_EXP_BASE = 16;
  localparam logic [DATA_W-1:0] PPC_MASK = 32'h00F0_00F3;
  localparam logic [DATA_W-1:0] BRG_MASK = 32'hFFFF_0000;

  localparam logic [ADDR_W-1:0] OFS_RESP   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_NSC    = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_MPC    = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_EN     = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_BRGEN  = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_IDBASE = 12'hFD0;

  typedef enum logic [2:0] {
    RD_ZERO, RD_RESP, RD_NSC, RD_MPC, RD_STAT, RD_EN, RD_BRGEN, RD_ID
  } rdSel_e;

  typedef struct packed {
    logic       wrResp;
    logic       wrNsc;
    logic       wrEn;
    logic       wrClr;
    logic       wrBrg;
    logic       rdEn;
    rdSel_e     rdSel;
    logic [3:0] idIdx;
    logic [1:0] lane;
    logic [1:0] size;
  } ctlStrobe_t;

  function automatic logic [7:0] idByte(input logic [3:0] idx, input bit variant);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'h04;
      4'd4:    b = 8'h52;
      4'd5:    b = 8'hB8;
      4'd6:    b = variant ? 8'h2B : 8'h0B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/sec_cfg_ctrl.sv
module sec_cfg_ctrl
  import sec_cfg_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output ctlStrobe_t        ctl
);
  logic [ADDR_W-1:0] wordAddr;
  logic [ADDR_W-1:0] idOfs;
  logic              wordWrite;
  logic              isId;

  assign wordAddr  = {busAddr[ADDR_W-1:2], 2'b00};
  assign wordWrite = busSel && busWrite && (busSize == 2'd2);
  assign isId      = (wordAddr >= OFS_IDBASE);
  assign idOfs     = wordAddr - OFS_IDBASE;

  always_comb begin
    ctl        = '0;
    ctl.rdSel  = RD_ZERO;
    ctl.rdEn   = busSel && !busWrite;
    ctl.lane   = busAddr[1:0];
    ctl.size   = busSize;
    ctl.idIdx  = idOfs[5:2];
    ctl.wrResp = wordWrite && (wordAddr == OFS_RESP);
    ctl.wrNsc  = wordWrite && (wordAddr == OFS_NSC);
    ctl.wrEn   = wordWrite && (wordAddr == OFS_EN);
    ctl.wrClr  = wordWrite && (wordAddr == OFS_CLR);
    ctl.wrBrg  = wordWrite && (wordAddr == OFS_BRGEN);
    case (wordAddr)
      OFS_RESP:  ctl.rdSel = RD_RESP;
      OFS_NSC:   ctl.rdSel = RD_NSC;
      OFS_MPC:   ctl.rdSel = RD_MPC;
      OFS_STAT:  ctl.rdSel = RD_STAT;
      OFS_EN:    ctl.rdSel = RD_EN;
      OFS_BRGEN: ctl.rdSel = RD_BRGEN;
      default:   ctl.rdSel = isId ? RD_ID : RD_ZERO;
    endcase
  end
endmodule

// File: rtl/sec_cfg_datapath.sv
module sec_cfg_datapath
  import sec_cfg_pkg::*;
#(
  parameter int unsigned NUM_MPC     = 4,
  parameter int unsigned NUM_EXP_MPC = 4,
  parameter bit          ID_VARIANT  = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             ctl,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  input  logic [NUM_MPC-1:0]     mpcIrq,
  input  logic [NUM_EXP_MPC-1:0] mpcExpIrq,
  input  logic [APB_PPCS-1:0]    apbPpcIrq,
  input  logic [EXP_PPCS-1:0]    apbExpPpcIrq,
  input  logic [EXP_PPCS-1:0]    ahbExpPpcIrq,
  output logic                   respCfgOut,
  output logic [1:0]             nscCfgOut,
  output logic [DATA_W-1:0]      ppcIntEnOut,
  output logic [DATA_W-1:0]      ppcIntStatOut
);
  logic              respQ;
  logic [1:0]        nscQ;
  logic [DATA_W-1:0] enQ;
  logic [DATA_W-1:0] brgQ;
  logic [DATA_W-1:0] mpcQ;
  logic [DATA_W-1:0] mpcVec;
  logic [DATA_W-1:0] irqVec;
  logic [DATA_W-1:0] clrVec;
  logic [DATA_W-1:0] statQ;
  logic [DATA_W-1:0] wordVal;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] laneVal;

  always_comb begin
    irqVec = '0;
    for (int i = 0; i < APB_PPCS; i++) irqVec[i] = apbPpcIrq[i];
    for (int i = 0; i < EXP_PPCS; i++) begin
      irqVec[APB_EXP_BASE + i] = apbExpPpcIrq[i];
      irqVec[AHB_EXP_BASE + i] = ahbExpPpcIrq[i];
    end
    mpcVec = '0;
    mpcVec[NUM_MPC-1:0] = mpcIrq;
    mpcVec[MPC_EXP_BASE +: NUM_EXP_MPC] = mpcExpIrq;
  end

  assign clrVec = ctl.wrClr ? (busWdata & PPC_MASK) : '0;

  // one sticky flop per implemented status position, constant zero elsewhere
  for (genvar b = 0; b < DATA_W; b++) begin : g_stat
    if (PPC_MASK[b]) begin : g_flop
      logic bitQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          bitQ <= 1'b0;
        else if (irqVec[b]) bitQ <= 1'b1;
        else if (clrVec[b]) bitQ <= 1'b0;
      end
      assign statQ[b] = bitQ;
    end else begin : g_tie
      assign statQ[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respQ <= 1'b0;
      nscQ  <= '0;
      enQ   <= '0;
      brgQ  <= '0;
      mpcQ  <= '0;
    end else begin
      mpcQ <= mpcVec;
      if (ctl.wrResp) respQ <= busWdata[0];
      if (ctl.wrNsc)  nscQ  <= busWdata[1:0];
      if (ctl.wrEn)   enQ   <= busWdata & PPC_MASK;
      if (ctl.wrBrg)  brgQ  <= busWdata & BRG_MASK;
    end
  end

  always_comb begin
    case (ctl.rdSel)
      RD_RESP:  wordVal = {{(DATA_W-1){1'b0}}, respQ};
      RD_NSC:   wordVal = {{(DATA_W-2){1'b0}}, nscQ};
      RD_MPC:   wordVal = mpcQ;
      RD_STAT:  wordVal = statQ;
      RD_EN:    wordVal = enQ;
      RD_BRGEN: wordVal = brgQ;
      RD_ID:    wordVal = {24'h0, idByte(ctl.idIdx, ID_VARIANT)};
      default:  wordVal = '0;
    endcase
    shifted = wordVal >> {ctl.lane, 3'b000};
    case (ctl.size)
      2'd0:    laneVal = {24'h0, shifted[7:0]};
      2'd1:    laneVal = {16'h0, shifted[15:0]};
      default: laneVal = wordVal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         busRdata <= '0;
    else if (ctl.rdEn) busRdata <= laneVal;
  end

  assign respCfgOut    = respQ;
  assign nscCfgOut     = nscQ;
  assign ppcIntEnOut   = enQ;
  assign ppcIntStatOut = statQ;

  assert_sticky_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqVec != '0) |=> ((statQ & $past(irqVec)) == $past(irqVec)));
  assert_brg_low_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrBrg |=> (brgQ[15:0] == 16'h0));
endmodule

// File: rtl/sec_cfg_regs.sv
module sec_cfg_regs
  import sec_cfg_pkg::*;
#(
  parameter int unsigned NUM_MPC     = 4,
  parameter int unsigned NUM_EXP_MPC = 4,
  parameter bit          ID_VARIANT  = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busSel,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [1:0]             busSize,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  input  logic [NUM_MPC-1:0]     mpcIrq,
  input  logic [NUM_EXP_MPC-1:0] mpcExpIrq,
  input  logic [APB_PPCS-1:0]    apbPpcIrq,
  input  logic [EXP_PPCS-1:0]    apbExpPpcIrq,
  input  logic [EXP_PPCS-1:0]    ahbExpPpcIrq,
  output logic                   respCfgOut,
  output logic [1:0]             nscCfgOut,
  output logic [DATA_W-1:0]      ppcIntEnOut,
  output logic [DATA_W-1:0]      ppcIntStatOut
);
  ctlStrobe_t ctl;

  sec_cfg_ctrl u_ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busSize (busSize),
    .ctl     (ctl)
  );

  sec_cfg_datapath #(
    .NUM_MPC    (NUM_MPC),
    .NUM_EXP_MPC(NUM_EXP_MPC),
    .ID_VARIANT (ID_VARIANT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .busWdata     (busWdata),
    .busRdata     (busRdata),
    .mpcIrq       (mpcIrq),
    .mpcExpIrq    (mpcExpIrq),
    .apbPpcIrq    (apbPpcIrq),
    .apbExpPpcIrq (apbExpPpcIrq),
    .ahbExpPpcIrq (ahbExpPpcIrq),
    .respCfgOut   (respCfgOut),
    .nscCfgOut    (nscCfgOut),
    .ppcIntEnOut  (ppcIntEnOut),
    .ppcIntStatOut(ppcIntStatOut)
  );

  logic [ADDR_W-1:0] wAddr;
  logic              fullWr;
  logic              narrowWr;
  assign wAddr    = {busAddr[ADDR_W-1:2], 2'b00};
  assign fullWr   = busSel && busWrite && (busSize == 2'd2);
  assign narrowWr = busSel && busWrite && (busSize != 2'd2);

  assert_resp_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fullWr && wAddr == OFS_RESP) |=> (respCfgOut == $past(busWdata[0])));
  assert_en_masked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fullWr && wAddr == OFS_EN) |=> (ppcIntEnOut == ($past(busWdata) & PPC_MASK)));
  assert_narrow_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    narrowWr |=> ($stable(ppcIntEnOut) && $stable(respCfgOut) && $stable(nscCfgOut)));
  assert_brg_stat_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && wAddr == 12'h040) |=> (busRdata == '0));
  assert_clear_effect_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fullWr && wAddr == OFS_CLR && apbPpcIrq == '0 && apbExpPpcIrq == '0 && ahbExpPpcIrq == '0)
      |=> ((ppcIntStatOut & $past(busWdata) & PPC_MASK) == '0));
endmodule

// File: tb/sec_cfg_regs_tb.sv
`timescale 1ns/1ps
module sec_cfg_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [1:0]  busSize = 2'd2;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, varRdata;
  logic [3:0]  mpcIrq = '0;
  logic [3:0]  mpcExpIrq = '0;
  logic [1:0]  apbPpcIrq = '0;
  logic [3:0]  apbExpPpcIrq = '0;
  logic [3:0]  ahbExpPpcIrq = '0;
  logic        respCfgOut, varResp;
  logic [1:0]  nscCfgOut, varNsc;
  logic [31:0] ppcIntEnOut, ppcIntStatOut, varEn, varStat;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sec_cfg_regs dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata), .mpcIrq(mpcIrq),
    .mpcExpIrq(mpcExpIrq), .apbPpcIrq(apbPpcIrq), .apbExpPpcIrq(apbExpPpcIrq),
    .ahbExpPpcIrq(ahbExpPpcIrq), .respCfgOut(respCfgOut), .nscCfgOut(nscCfgOut),
    .ppcIntEnOut(ppcIntEnOut), .ppcIntStatOut(ppcIntStatOut));

  sec_cfg_regs #(.ID_VARIANT(1'b1)) dutVar_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .busRdata(varRdata), .mpcIrq(mpcIrq),
    .mpcExpIrq(mpcExpIrq), .apbPpcIrq(apbPpcIrq), .apbExpPpcIrq(apbExpPpcIrq),
    .ahbExpPpcIrq(ahbExpPpcIrq), .respCfgOut(varResp), .nscCfgOut(varNsc),
    .ppcIntEnOut(varEn), .ppcIntStatOut(varStat));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; busSize = sz;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a; busSize = sz;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    check("R1 resp", {31'h0, respCfgOut}, 32'h0);
    check("R1 nsc", {30'h0, nscCfgOut}, 32'h0);
    check("R1 en", ppcIntEnOut, 32'h0);
    check("R1 stat", ppcIntStatOut, 32'h0);
    check("R1 rdata", busRdata, 32'h0);
    rd(12'h048, v); check("R1 brg enable", v, 32'h0);
  endtask

  task automatic test_cfg_bits();
    logic [31:0] v;
    wr(12'h010, 32'hFFFF_FFFF);
    check("R5 resp out", {31'h0, respCfgOut}, 32'h1);
    rd(12'h010, v); check("R5 resp read", v, 32'h1);
    wr(12'h010, 32'h0000_0002);
    check("R5 resp bit0 only", {31'h0, respCfgOut}, 32'h0);
    wr(12'h014, 32'hFFFF_FFFE);
    check("R5 nsc out", {30'h0, nscCfgOut}, 32'h2);
    rd(12'h014, v); check("R5 nsc read", v, 32'h2);
  endtask

  task automatic test_enable_and_lanes();
    logic [31:0] v;
    wr(12'h028, 32'hFFFF_FFFF);
    check("R6 enable out", ppcIntEnOut, 32'h00F0_00F3);
    rd(12'h028, v); check("R6 enable read", v, 32'h00F0_00F3);
    rd(12'h029, v); check("R2 low addr bits ignored", v, 32'h00F0_00F3);
    rd(12'h028, v, 2'd0); check("R3 byte lane0", v, 32'h0000_00F3);
    rd(12'h02A, v, 2'd0); check("R3 byte lane2", v, 32'h0000_00F0);
    rd(12'h02A, v, 2'd1); check("R3 half upper", v, 32'h0000_00F0);
    rd(12'h028, v, 2'd1); check("R3 half lower", v, 32'h0000_00F3);
    rd(12'h028, v, 2'd3); check("R3 code3 as word", v, 32'h00F0_00F3);
  endtask

  task automatic test_narrow_writes();
    logic [31:0] v;
    wr(12'h028, 32'h0, 2'd0);
    wr(12'h028, 32'h0, 2'd1);
    check("R4 enable kept", ppcIntEnOut, 32'h00F0_00F3);
    wr(12'h014, 32'h0, 2'd0);
    check("R4 nsc kept", {30'h0, nscCfgOut}, 32'h2);
    wr(12'h010, 32'h1, 2'd1);
    check("R4 resp kept", {31'h0, respCfgOut}, 32'h0);
    rd(12'h028, v); check("R4 enable readback", v, 32'h00F0_00F3);
  endtask

  task automatic test_status();
    logic [31:0] v;
    @(negedge clk);
    apbPpcIrq = 2'b01; ahbExpPpcIrq = 4'b0100; apbExpPpcIrq = 4'b1000;
    @(negedge clk);
    apbPpcIrq = '0; ahbExpPpcIrq = '0; apbExpPpcIrq = '0;
    rd(12'h020, v); check("R7 status placement", v, 32'h0040_0081);
    check("R7 status out", ppcIntStatOut, 32'h0040_0081);
    wr(12'h020, 32'h0);
    rd(12'h020, v); check("R11 status write ignored", v, 32'h0040_0081);
    wr(12'h024, 32'h0000_0001);
    rd(12'h020, v); check("R8 clear bit0", v, 32'h0040_0080);
    wr(12'h024, 32'hFFFF_FFFF);
    rd(12'h020, v); check("R8 clear all", v, 32'h0);
    @(negedge clk); apbPpcIrq = 2'b10; ahbExpPpcIrq = 4'b1000;
    @(negedge clk); ahbExpPpcIrq = '0;
    wr(12'h024, 32'h0080_0002);
    rd(12'h020, v); check("R8 held request beats clear", v, 32'h0000_0002);
    @(negedge clk); apbPpcIrq = '0;
    wr(12'h024, 32'h0000_0002);
    rd(12'h020, v); check("R8 clear after release", v, 32'h0);
  endtask

  task automatic test_mpc();
    logic [31:0] v;
    @(negedge clk); mpcIrq = 4'b1010; mpcExpIrq = 4'b0011;
    rd(12'h01C, v); check("R9 mpc status", v, 32'h0003_000A);
    wr(12'h01C, 32'hFFFF_FFFF);
    rd(12'h01C, v); check("R9 mpc write ignored", v, 32'h0003_000A);
    @(negedge clk); mpcIrq = 4'b0001; mpcExpIrq = 4'b1000;
    rd(12'h01C, v); check("R9 mpc follows level", v, 32'h0008_0001);
  endtask

  task automatic test_bridge_and_holes();
    logic [31:0] v;
    wr(12'h048, 32'hFFFF_FFFF);
    rd(12'h048, v); check("R10 brg enable mask", v, 32'hFFFF_0000);
    wr(12'h044, 32'hFFFF_FFFF);
    rd(12'h048, v); check("R10 brg clear no effect", v, 32'hFFFF_0000);
    wr(12'h040, 32'hFFFF_FFFF);
    rd(12'h040, v); check("R10 brg status zero", v, 32'h0);
    rd(12'h024, v); check("R11 clear reads zero", v, 32'h0);
    rd(12'h044, v); check("R11 brg clear reads zero", v, 32'h0);
    rd(12'h100, v); check("R11 hole reads zero", v, 32'h0);
  endtask

  task automatic test_ids();
    logic [31:0] v;
    logic [7:0] exp [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h52, 8'hB8,
                            8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 12; i++) begin
      rd(12'hFD0 + 12'(4 * i), v);
      check($sformatf("R12 id byte %0d", i), v, {24'h0, exp[i]});
    end
    wr(12'hFD0, 32'hFFFF_FFFF);
    rd(12'hFD0, v); check("R11 id write ignored", v, 32'h0000_0004);
    rd(12'hFE8, v); check("R12 variant0 pid2", v, 32'h0000_000B);
    check("R12 variant1 pid2", varRdata, 32'h0000_002B);
  endtask

  task automatic test_rereset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R1 enable after reset", ppcIntEnOut, 32'h0);
    check("R1 nsc after reset", {30'h0, nscCfgOut}, 32'h0);
    test_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_cfg_bits();
    test_enable_and_lanes();
    test_narrow_writes();
    test_status();
    test_mpc();
    test_bridge_and_holes();
    test_ids();
    wr(12'h028, 32'hFFFF_FFFF);
    wr(12'h014, 32'h3);
    test_rereset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule